// File: doc/BRIEF.md
# Temperature Measurement Sequencer

This block paces temperature measurements and turns the raw readings of an analog front end into stored temperature values. Each measurement cycle asks the converter for a local-diode reading and then for a remote-diode reading. Both requests go through a request/acknowledge port that returns signed readings in quarter-degree steps. A signed calibration offset is added to the remote reading. Both results are then put into the selected range format, clamped, and written to the output registers together. A one-cycle completion strobe tells the downstream alarm comparators that a new pair of values is ready.

Cycles run on a timer whose rate a control code picks, in powers of two. A standby control stops periodic cycles. Raising standby abandons a cycle in progress without touching any stored value. While the block is in standby, a one-shot pulse runs exactly one cycle. A busy output is high for the whole cycle.

Top module: `temp_conv_seq`

## Requirements
- R1: Periodic cycles start every (CLK_HZ*16) >> k clock cycles, where k is `rate_code` for codes 0 to 10. Any code above 10 acts as 10. The timer restarts from zero when standby is released.
- R2: A cycle first requests the local channel (`adc_sel`=0) and then the remote channel (`adc_sel`=1). `adc_req` and `adc_sel` stay steady until `adc_ack`.
- R3: The remote offset is the two's-complement quarter-degree value {`ofs_hi`,`ofs_frac`}. It is added to the raw remote reading before formatting. `remote_hi` holds the integer degrees, `remote_lo` bits 7:6 hold the quarter fraction, and `remote_lo` bits 5:0 are always 0.
- R4: In normal range (`ext_range`=0), the remote value is clamped to 0..127.75 and the local value to 0..127.
- R5: In extended range (`ext_range`=1), 64 degrees is added. The remote value is clamped to 0..255.75 and the local value to 0..255.
- R6: The local value is the raw quarter-degree reading rounded down to whole degrees (floor, also for negative readings).
- R7: While `standby` is high, no periodic cycle starts. A rise of `standby` during a cycle abandons it: `busy` falls, no `done` is issued, and the outputs keep their values.
- R8: A one-shot pulse while in standby and idle starts exactly one cycle. The block is idle again afterwards. A pulse outside standby or during a cycle has no effect.
- R9: `busy` is high from the start of a cycle until its results are stored or the cycle is abandoned.
- R10: `done` is a single-cycle pulse in the same cycle the new values appear. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 8 | Measurement rate code |
| standby | input | 1 | Standby control |
| ext_range | input | 1 | 1 selects extended (offset +64) format |
| oneshot_wr | input | 1 | Single-measurement trigger pulse |
| ofs_hi | input | 8 | Remote offset, signed integer degrees |
| ofs_frac | input | 2 | Remote offset, quarter-degree fraction |
| adc_req | output | 1 | Conversion request |
| adc_sel | output | 1 | Channel select, 0 local, 1 remote |
| adc_ack | input | 1 | Conversion complete, data valid |
| adc_data | input | RAW_W | Signed raw reading, quarter-degree LSB |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Results stored strobe |
| local_temp | output | 8 | Local temperature |
| remote_hi | output | 8 | Remote temperature, integer part |
| remote_lo | output | 8 | Remote temperature, fraction in bits 7:6 |

## Verification
The properties assume that `adc_ack` is a single-cycle pulse given only while `adc_req` is high. They also assume that `oneshot_wr` is a pulse and that `ext_range` does not change while `done` is high. The bench's converter model raises `adc_ack` for one cycle after a programmable latency, and only while a request is pending. All control inputs change at the falling edge, and `ext_range` changes only while the block is idle.

// File: rtl/temp_seq_pkg.sv
package temp_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOCAL  = 2'd1,
        ST_REMOTE = 2'd2
    } seq_state_e;

    localparam int RATE_TOP_CODE = 10;
    localparam int EXT_SHIFT_DEG = 64;

    typedef struct packed {
        logic [7:0] local_t;
        logic [9:0] remote_q;
    } temp_result_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [3:0] eff_rate(input logic [7:0] code);
        if (code > 8'(RATE_TOP_CODE)) return 4'(RATE_TOP_CODE);
        return code[3:0];
    endfunction

    // quarter-degree reading -> whole degrees (floor), range shifted, clamped
    function automatic logic [7:0] fmt_local(input int q, input logic ext);
        int d;
        d = q >>> 2;
        if (ext) d = d + EXT_SHIFT_DEG;
        return 8'(clamp_int(d, 0, ext ? 255 : 127));
    endfunction

    // quarter-degree reading -> 10-bit quarter-degree code, range shifted, clamped
    function automatic logic [9:0] fmt_remote(input int q, input logic ext);
        int v;
        v = q;
        if (ext) v = v + EXT_SHIFT_DEG * 4;
        return 10'(clamp_int(v, 0, ext ? 1023 : 511));
    endfunction

endpackage

// File: rtl/rate_timer.sv
module rate_timer #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  logic [7:0] rate_code,
    output logic       tick
);
    import temp_seq_pkg::*;

    localparam longint BASE  = longint'(CLK_HZ) * 16;
    localparam int     CNT_W = $clog2(BASE + 1);

    logic [CNT_W-1:0] base_cycles;
    logic [CNT_W-1:0] period_m1;
    logic [CNT_W-1:0] cnt;

    assign base_cycles = CNT_W'(BASE);
    assign period_m1   = (base_cycles >> eff_rate(rate_code)) - CNT_W'(1);
    assign tick        = !standby && (cnt >= period_m1);

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic standby,
    input  logic oneshot_wr,
    input  logic adc_ack,
    output logic adc_req,
    output logic adc_sel,
    output logic busy,
    output logic cap_local,
    output logic commit
);
    import temp_seq_pkg::*;

    seq_state_e state;
    logic       standby_q;
    logic       abort;
    logic       start;

    assign abort     = standby && !standby_q;
    assign start     = tick || (standby && oneshot_wr);
    assign busy      = (state != ST_IDLE);
    assign adc_req   = busy;
    assign adc_sel   = (state == ST_REMOTE);
    assign cap_local = (state == ST_LOCAL)  && adc_ack && !abort;
    assign commit    = (state == ST_REMOTE) && adc_ack && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            standby_q <= 1'b0;
        end else begin
            standby_q <= standby;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_LOCAL;
                end
                ST_LOCAL: begin
                    if (abort)        state <= ST_IDLE;
                    else if (adc_ack) state <= ST_REMOTE;
                end
                ST_REMOTE: begin
                    if (abort || adc_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/result_store.sv
module result_store #(
    parameter int RAW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_local,
    input  logic             commit,
    input  logic             ext_range,
    input  logic [7:0]       ofs_hi,
    input  logic [1:0]       ofs_frac,
    input  logic [RAW_W-1:0] adc_data,
    output logic             done,
    output logic [7:0]       local_temp,
    output logic [7:0]       remote_hi,
    output logic [7:0]       remote_lo
);
    import temp_seq_pkg::*;

    localparam int OFS_W = 10;

    logic [RAW_W-1:0] local_raw;
    logic [OFS_W-1:0] ofs_q;
    int               remote_sum;
    temp_result_t     res;

    assign ofs_q      = {ofs_hi, ofs_frac};
    assign remote_sum = int'($signed(adc_data)) + int'($signed(ofs_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            local_raw <= '0;
            res       <= '0;
            done      <= 1'b0;
        end else begin
            done <= commit;
            if (cap_local) local_raw <= adc_data;
            if (commit) begin
                res.local_t  <= fmt_local(int'($signed(local_raw)), ext_range);
                res.remote_q <= fmt_remote(remote_sum, ext_range);
            end
        end
    end

    assign local_temp = res.local_t;
    assign remote_hi  = res.remote_q[9:2];
    assign remote_lo  = {res.remote_q[1:0], 6'b0};
endmodule

// File: rtl/temp_conv_seq.sv
module temp_conv_seq #(
    parameter int CLK_HZ = 100_000_000,
    parameter int RAW_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rate_code,
    input  logic             standby,
    input  logic             ext_range,
    input  logic             oneshot_wr,
    input  logic [7:0]       ofs_hi,
    input  logic [1:0]       ofs_frac,
    output logic             adc_req,
    output logic             adc_sel,
    input  logic             adc_ack,
    input  logic [RAW_W-1:0] adc_data,
    output logic             busy,
    output logic             done,
    output logic [7:0]       local_temp,
    output logic [7:0]       remote_hi,
    output logic [7:0]       remote_lo
);
    logic tick;
    logic cap_local;
    logic commit;

    rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .rate_code (rate_code),
        .tick      (tick)
    );

    conv_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .standby    (standby),
        .oneshot_wr (oneshot_wr),
        .adc_ack    (adc_ack),
        .adc_req    (adc_req),
        .adc_sel    (adc_sel),
        .busy       (busy),
        .cap_local  (cap_local),
        .commit     (commit)
    );

    result_store #(.RAW_W(RAW_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .cap_local  (cap_local),
        .commit     (commit),
        .ext_range  (ext_range),
        .ofs_hi     (ofs_hi),
        .ofs_frac   (ofs_frac),
        .adc_data   (adc_data),
        .done       (done),
        .local_temp (local_temp),
        .remote_hi  (remote_hi),
        .remote_lo  (remote_lo)
    );
endmodule

// File: rtl/temp_seq_chk.sv
module temp_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       standby,
    input logic       ext_range,
    input logic       oneshot_wr,
    input logic       adc_req,
    input logic       adc_sel,
    input logic       adc_ack,
    input logic       busy,
    input logic       done,
    input logic [7:0] local_temp,
    input logic [7:0] remote_hi,
    input logic [7:0] remote_lo
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_ack && !$rose(standby)) |=> adc_req);

    assert_sel_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_ack && !$rose(standby)) |=> $stable(adc_sel));

    assert_lo_zero_R3: assert property (@(posedge clk) disable iff (rst)
        remote_lo[5:0] == 6'b0);

    assert_norm_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(ext_range)) |-> (local_temp <= 8'd127 && remote_hi <= 8'd127));

    assert_standby_start_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(standby)) |-> $past(oneshot_wr));

    assert_busy_req_R9: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

bind temp_conv_seq temp_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .standby    (standby),
    .ext_range  (ext_range),
    .oneshot_wr (oneshot_wr),
    .adc_req    (adc_req),
    .adc_sel    (adc_sel),
    .adc_ack    (adc_ack),
    .busy       (busy),
    .done       (done),
    .local_temp (local_temp),
    .remote_hi  (remote_hi),
    .remote_lo  (remote_lo)
);

// File: tb/sim_temp_conv_seq.sv
`timescale 1ns/1ps
module sim_temp_conv_seq;
    localparam int CLK_HZ = 4096;
    localparam int RAW_W  = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       rate_code = 8'd10;
    logic             standby = 1'b0;
    logic             ext_range = 1'b0;
    logic             oneshot_wr = 1'b0;
    logic [7:0]       ofs_hi = 8'd0;
    logic [1:0]       ofs_frac = 2'd0;
    logic             adc_req, adc_sel, adc_ack = 1'b0;
    logic [RAW_W-1:0] adc_data;
    logic             busy, done;
    logic [7:0]       local_temp, remote_hi, remote_lo;

    int loc_raw = 0, rem_raw = 0, adc_lat = 2, wcnt = 0;
    int checks = 0, fails = 0, cyc = 0;
    int m_cnt = 0, m_state = 0, m_hold = 0, m_loc = 0, m_rem = 0, m_done = 0, m_sbq = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign adc_data = adc_sel ? RAW_W'(rem_raw) : RAW_W'(loc_raw);

    temp_conv_seq #(.CLK_HZ(CLK_HZ), .RAW_W(RAW_W)) u0 (
        .clk(clk), .rst(rst), .rate_code(rate_code), .standby(standby),
        .ext_range(ext_range), .oneshot_wr(oneshot_wr), .ofs_hi(ofs_hi),
        .ofs_frac(ofs_frac), .adc_req(adc_req), .adc_sel(adc_sel),
        .adc_ack(adc_ack), .adc_data(adc_data), .busy(busy), .done(done),
        .local_temp(local_temp), .remote_hi(remote_hi), .remote_lo(remote_lo));

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction
    // local: floor to degrees, +64 if extended, clamp
    function automatic int e_loc(int q, bit ext);
        int d = (q >= 0) ? q / 4 : -((-q + 3) / 4);
        return ext ? lim(d + 64, 0, 255) : lim(d, 0, 127);
    endfunction
    // remote: quarter-degree code, +256 quarters if extended, clamp
    function automatic int e_rem(int q, bit ext);
        return ext ? lim(q + 256, 0, 1023) : lim(q, 0, 511);
    endfunction
    function automatic int ofs_val();
        int v = int'(ofs_hi) * 4 + int'(ofs_frac);
        return (v >= 512) ? v - 1024 : v;
    endfunction
    function automatic int period();
        int k = (rate_code > 8'd10) ? 10 : int'(rate_code);
        return (CLK_HZ * 16) >> k;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // cycle reference model
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_state = 0; m_hold = 0; m_loc = 0; m_rem = 0; m_done = 0; m_sbq = 0;
        end else begin
            bit ab, tk;
            int raw;
            ab = standby && (m_sbq == 0);
            tk = !standby && (m_cnt >= period() - 1);
            raw = int'($signed(adc_data));
            m_done = 0;
            case (m_state)
                0: if (tk || (standby && oneshot_wr)) m_state = 1;
                1: if (ab) m_state = 0; else if (adc_ack) begin m_hold = raw; m_state = 2; end
                default: if (ab) m_state = 0;
                         else if (adc_ack) begin
                             m_loc = e_loc(m_hold, ext_range);
                             m_rem = e_rem(raw + ofs_val(), ext_range);
                             m_done = 1; m_state = 0;
                         end
            endcase
            if (standby || tk) m_cnt = 0; else m_cnt++;
            m_sbq = standby;
        end
    end

    // converter model and per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (adc_req && !adc_ack) begin
            if (wcnt >= adc_lat) begin adc_ack <= 1'b1; wcnt = 0; end
            else wcnt++;
        end else begin
            adc_ack <= 1'b0; wcnt = 0;
        end
        if (!rst && !finished) begin
            chk("R9 busy", busy, m_state != 0);
            chk("R2 adc_req", adc_req, m_state != 0);
            chk("R2 adc_sel", adc_sel, m_state == 2);
            chk("R10 done", done, m_done);
            chk("R6 local_temp", local_temp, m_loc);
            chk("R3 remote_hi", remote_hi, m_rem >> 2);
            chk("R3 remote_lo", remote_lo, (m_rem & 3) << 6);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_done(string req);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic wait_rise(output int at);
        bit prev = busy;
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (busy && !prev) begin at = cyc; return; end
            prev = busy;
        end
    endtask

    task automatic interval(string req, int exp);
        int a, b;
        wait_rise(a);
        wait_rise(b);
        chk(req, b - a, exp);
    endtask

    initial begin
        int rises, dones;
        repeat (3) @(negedge clk);
        chk("R10 reset local", local_temp, 0);
        chk("R10 reset remote_hi", remote_hi, 0);
        chk("R10 reset busy", busy, 0);
        rst = 1'b0;

        // R6/R3 basic values, normal range
        loc_raw = 25 * 4 + 3; rem_raw = 50 * 4 + 1;
        wait_done("R2 first cycle");
        chk("R6 local floor 25.75", local_temp, 25);
        chk("R3 remote 50.25 hi", remote_hi, 50);
        chk("R3 remote 50.25 lo", remote_lo, 8'h40);
        interval("R1 code 10 interval", 64);

        // R3 negative offset -3.5
        ofs_hi = 8'hFC; ofs_frac = 2'b10;
        wait_done("R3 cycle");
        wait_done("R3 cycle");
        chk("R3 offset hi", remote_hi, 46);
        chk("R3 offset lo", remote_lo, 8'hC0);
        ofs_hi = 0; ofs_frac = 0;

        // R4 clamps
        rem_raw = 130 * 4; loc_raw = -8;
        wait_done("R4 cycle"); wait_done("R4 cycle");
        chk("R4 remote high clamp hi", remote_hi, 127);
        chk("R4 remote high clamp lo", remote_lo, 8'hC0);
        chk("R4 local low clamp", local_temp, 0);
        rem_raw = -40; loc_raw = 200 * 4;
        wait_done("R4 cycle"); wait_done("R4 cycle");
        chk("R4 remote low clamp", remote_hi, 0);
        chk("R4 local high clamp", local_temp, 127);

        // R5 extended range
        wait_done("R5 sync"); ext_range = 1'b1;
        rem_raw = -55 * 4; loc_raw = 150 * 4;
        wait_done("R5 cycle");
        chk("R5 remote -55 ext", remote_hi, 9);
        chk("R5 local 150 ext", local_temp, 214);
        rem_raw = 300 * 4; loc_raw = -1;
        wait_done("R5 cycle"); wait_done("R5 cycle");
        chk("R5 remote clamp ext", remote_hi, 255);
        chk("R6 local -0.25 ext", local_temp, 63);
        wait_done("sync"); ext_range = 1'b0; loc_raw = 20 * 4; rem_raw = 30 * 4;

        // R1 rate codes
        rate_code = 8'h0F; wait_rise(rises);
        interval("R1 reserved code 0F", 64);
        rate_code = 8'd8; wait_rise(rises);
        interval("R1 code 8 interval", 256);

        // R7 abort on standby
        wait_done("R7 sync");
        adc_lat = 20; loc_raw = 99 * 4; rem_raw = 99 * 4;
        wait_rise(rises);
        repeat (5) @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        chk("R7 busy dropped", busy, 0);
        dones = 0; rises = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) dones++;
            if (busy) rises++;
        end
        chk("R7 no done after abort", dones, 0);
        chk("R7 no cycle in standby", rises, 0);
        chk("R7 local kept", local_temp, 20);

        // R8 one-shot
        adc_lat = 6;
        oneshot_wr = 1'b1; @(negedge clk); oneshot_wr = 1'b0;
        dones = 0;
        repeat (3) @(negedge clk);
        oneshot_wr = 1'b1; @(negedge clk); oneshot_wr = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R8 exactly one cycle", dones, 1);
        chk("R8 one-shot result", local_temp, 99);
        chk("R8 idle after", busy, 0);

        // R8 one-shot ignored in run mode
        rate_code = 8'd6; standby = 1'b0;
        @(negedge clk);
        oneshot_wr = 1'b1; @(negedge clk); oneshot_wr = 1'b0;
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) rises++;
        end
        chk("R8 run-mode one-shot ignored", rises, 0);
        interval("R1 code 6 interval", 1024);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule